// File: doc/BRIEF.md
# Program Flow Trace Capture

This block records program-flow events from a processor core into an on-chip circular trace RAM. Each cycle the core may report an issued execution set, a change of flow, an interrupt service or an executed mark instruction. A control register chooses which of these event classes are recorded and whether counter snapshots are attached. A recorded event becomes a group of one to four words. The group is placed in a small staging queue, and the queue drains into the trace RAM one word per cycle through a write pointer.

Tracing is switched on and off by the control register or by two external strobes. Software reads the captured words back through a read-data port addressed by a 16-bit read pointer, which steps after every read. A status flag reports whether the write pointer has wrapped since tracing was last switched on.

Top module: `flow_trace_capture`

## Requirements
- R1: The control register is written whole by `ctrl_we`/`ctrl_wdata` and read on `ctrl_q`, resetting to 0. Its bit layout: bit 0 change-of-flow, bit 1 interrupt, bit 2 issue, bit 3 mark, bit 4 enable, bit 5 attach event counter, bit 6 attach extension counter.
- R2: `ev_start` sets bit 4 and `ev_stop` clears it. `ev_stop` wins over `ev_start`, and both win over bit 4 of a software write in the same cycle. A software write's other bits are still taken.
- R3: When bit 4 goes from 0 to 1, the read pointer, the write pointer and the wrap flag all return to 0.
- R4: With the issue bit set, each `iss_vld` cycle records one word, `iss_addr`.
- R5: With the mark bit set, each `mark_vld` cycle records one word, `mark_pc`. With it clear, mark events record nothing.
- R6: With the change-of-flow bit set, `cof_vld` records `cof_src` and then `cof_dst`. A third word follows: `evt_cnt` if bit 5 is set, otherwise `ext_cnt` if bit 6 is set.
- R7: With the interrupt bit set, `irq_vld` records `irq_last` and then `irq_vec`. It then adds `evt_cnt` if bit 5 is set and `ext_cnt` if bit 6 is set, in that order, each word in its own RAM write cycle.
- R8: At most one group is formed per cycle, with priority interrupt > change-of-flow > mark > issue. An event whose class bit is clear is not recorded.
- R9: A group is captured at the clock edge that samples its event. The staging queue holds QD words. The head word is written to RAM at the write pointer on each later enabled edge, one word per edge. A group larger than the free slots at capture is dropped entirely.
- R10: While bit 4 is 0, nothing is captured, nothing is written to RAM, and the staging queue is emptied.
- R11: The write pointer wraps modulo DEPTH. The wrap flag sets on a wrap and holds until the next enable.
- R12: `rd_data` is the RAM word at the read pointer. `rd_req` advances the read pointer by one, returning to 0 after DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 7 | Control register write value |
| ctrl_q | output | 7 | Control register contents |
| ev_start | input | 1 | External trace enable strobe |
| ev_stop | input | 1 | External trace disable strobe |
| iss_vld | input | 1 | Execution set issued |
| iss_addr | input | DW | First address of the issued set |
| cof_vld | input | 1 | Set containing a change of flow executed |
| cof_src | input | DW | Start address of that set |
| cof_dst | input | DW | Change-of-flow target |
| irq_vld | input | 1 | Interrupt serviced |
| irq_last | input | DW | Last set address before the interrupt |
| irq_vec | input | DW | Interrupt vector address |
| mark_vld | input | 1 | Mark instruction executed |
| mark_pc | input | DW | Program counter of the mark |
| evt_cnt | input | DW | Event counter value |
| ext_cnt | input | DW | Extension counter value |
| rd_req | input | 1 | Software read strobe |
| rd_data | output | DW | RAM word at the read pointer |
| rd_ptr | output | 16 | Read pointer |
| wr_ptr | output | log2(DEPTH) | Write pointer |
| wrapped | output | 1 | Write pointer wrapped since enable |

## Verification
Two situations are the hardest to reach from the ports. The first is a group being dropped because the staging queue lacks room. The second is the queue being emptied by a disable while words are still waiting. To reach the first, the stimulus fires four-word interrupt groups on back-to-back cycles, so the queue fills faster than it drains and the third group must be rejected whole. To reach the second, the stop strobe is pulsed one cycle after a capture, so exactly one word reaches RAM. A long random phase then mixes every mode, strobe and read against a cycle-level model of the queue and pointers.

// File: rtl/flow_trace_capture.sv
module flow_trace_capture #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int QD    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_we,
  input  logic [6:0]               ctrl_wdata,
  output logic [6:0]               ctrl_q,
  input  logic                     ev_start,
  input  logic                     ev_stop,
  input  logic                     iss_vld,
  input  logic [DW-1:0]            iss_addr,
  input  logic                     cof_vld,
  input  logic [DW-1:0]            cof_src,
  input  logic [DW-1:0]            cof_dst,
  input  logic                     irq_vld,
  input  logic [DW-1:0]            irq_last,
  input  logic [DW-1:0]            irq_vec,
  input  logic                     mark_vld,
  input  logic [DW-1:0]            mark_pc,
  input  logic [DW-1:0]            evt_cnt,
  input  logic [DW-1:0]            ext_cnt,
  input  logic                     rd_req,
  output logic [DW-1:0]            rd_data,
  output logic [15:0]              rd_ptr,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic                     wrapped
);
  localparam int RAW = $clog2(DEPTH);
  localparam int QAW = $clog2(QD);
  localparam int QCW = QAW + 1;

  logic [6:0] ctrl, ctrl_n;
  logic       en, en_rise;

  always_comb begin
    ctrl_n = ctrl_we ? ctrl_wdata : ctrl;
    if (ev_start) ctrl_n[4] = 1'b1;
    if (ev_stop)  ctrl_n[4] = 1'b0;
  end

  assign en      = ctrl[4];
  assign en_rise = !ctrl[4] && ctrl_n[4];
  assign ctrl_q  = ctrl;

  always_ff @(posedge clk)
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_n;

  logic [DW-1:0] g [4];
  logic [2:0]    gn;

  always_comb begin
    for (int i = 0; i < 4; i++) g[i] = '0;
    gn = 3'd0;
    if (irq_vld && ctrl[1]) begin
      g[0] = irq_last;
      g[1] = irq_vec;
      gn   = 3'd2;
      if (ctrl[5]) begin g[gn[1:0]] = evt_cnt; gn = gn + 3'd1; end
      if (ctrl[6]) begin g[gn[1:0]] = ext_cnt; gn = gn + 3'd1; end
    end else if (cof_vld && ctrl[0]) begin
      g[0] = cof_src;
      g[1] = cof_dst;
      gn   = 3'd2;
      if (ctrl[5])      begin g[2] = evt_cnt; gn = 3'd3; end
      else if (ctrl[6]) begin g[2] = ext_cnt; gn = 3'd3; end
    end else if (mark_vld && ctrl[3]) begin
      g[0] = mark_pc;
      gn   = 3'd1;
    end else if (iss_vld && ctrl[2]) begin
      g[0] = iss_addr;
      gn   = 3'd1;
    end
  end

  logic [DW-1:0]  q [QD];
  logic [QAW-1:0] qh, qt;
  logic [QCW-1:0] qc;
  logic           push, pop;

  assign pop  = en && (qc != '0);
  assign push = en && (gn != 3'd0) && (int'(qc) + int'(gn) <= QD);

  always_ff @(posedge clk)
    for (int i = 0; i < 4; i++)
      if (push && i < int'(gn)) q[qt + QAW'(i)] <= g[i];

  always_ff @(posedge clk)
    if (!rst_n || !en) begin
      qh <= '0;
      qt <= '0;
      qc <= '0;
    end else begin
      if (push) qt <= qt + QAW'(gn);
      if (pop)  qh <= qh + 1'b1;
      qc <= qc + (push ? QCW'(gn) : '0) - QCW'(pop);
    end

  logic [DW-1:0]  ram [DEPTH];
  logic [RAW-1:0] wp;
  logic [15:0]    rp;
  logic           wrap_q;

  always_ff @(posedge clk)
    if (pop) ram[wp] <= q[qh];

  always_ff @(posedge clk)
    if (!rst_n || en_rise) begin
      wp     <= '0;
      wrap_q <= 1'b0;
    end else if (pop) begin
      wp <= wp + 1'b1;
      if (wp == RAW'(DEPTH-1)) wrap_q <= 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n || en_rise) rp <= '0;
    else if (rd_req)       rp <= (rp == 16'(DEPTH-1)) ? 16'd0 : rp + 16'd1;

  assign rd_data = ram[rp[RAW-1:0]];
  assign rd_ptr  = rp;
  assign wr_ptr  = wp;
  assign wrapped = wrap_q;

  a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !ctrl_q[4]);

  a_r3_enable_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[4]) |-> (rd_ptr == 16'd0 && wr_ptr == '0 && !wrapped));

  a_r9_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(qc) <= QD);

  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[4] && !ctrl_n[4]) |=> $stable(wr_ptr));

  a_r11_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapped) |-> wr_ptr == '0);

  a_r12_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ctrl_q[4]) |=>
      rd_ptr == (($past(rd_ptr) == 16'(DEPTH-1)) ? 16'd0 : $past(rd_ptr) + 16'd1));
endmodule

// File: tb/flow_trace_capture_tb_top.sv
module flow_trace_capture_tb_top;
  localparam int DW = 32, DEPTH = 64, QD = 8;

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, ev_start = 0, ev_stop = 0;
  logic [6:0] ctrl_wdata = 0, ctrl_q;
  logic iss_vld = 0, cof_vld = 0, irq_vld = 0, mark_vld = 0, rd_req = 0;
  logic [DW-1:0] iss_addr = 0, cof_src = 0, cof_dst = 0, irq_last = 0, irq_vec = 0;
  logic [DW-1:0] mark_pc = 0, evt_cnt = 0, ext_cnt = 0, rd_data;
  logic [15:0] rd_ptr;
  logic [$clog2(DEPTH)-1:0] wr_ptr;
  logic wrapped;

  always #5 clk = ~clk;

  flow_trace_capture #(.DW(DW), .DEPTH(DEPTH), .QD(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .ev_start(ev_start), .ev_stop(ev_stop), .iss_vld(iss_vld), .iss_addr(iss_addr),
    .cof_vld(cof_vld), .cof_src(cof_src), .cof_dst(cof_dst), .irq_vld(irq_vld),
    .irq_last(irq_last), .irq_vec(irq_vec), .mark_vld(mark_vld), .mark_pc(mark_pc),
    .evt_cnt(evt_cnt), .ext_cnt(ext_cnt), .rd_req(rd_req), .rd_data(rd_data),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .wrapped(wrapped));

  int checks = 0, errors = 0;
  bit model_on = 0;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle-level reference model
  logic [6:0]    m_ctrl;
  logic [DW-1:0] mq [QD];
  logic [DW-1:0] mram [DEPTH];
  bit            mval [DEPTH];
  int            mh, mt, mc, mwp, mrp;
  bit            mwrap;

  function automatic void build(input logic [6:0] c, output logic [DW-1:0] w [4], output int n);
    for (int i = 0; i < 4; i++) w[i] = '0;
    n = 0;
    if (irq_vld && c[1]) begin
      w[0] = irq_last; w[1] = irq_vec; n = 2;
      if (c[5]) begin w[n] = evt_cnt; n++; end
      if (c[6]) begin w[n] = ext_cnt; n++; end
    end else if (cof_vld && c[0]) begin
      w[0] = cof_src; w[1] = cof_dst; n = 2;
      if (c[5]) begin w[2] = evt_cnt; n = 3; end
      else if (c[6]) begin w[2] = ext_cnt; n = 3; end
    end else if (mark_vld && c[3]) begin
      w[0] = mark_pc; n = 1;
    end else if (iss_vld && c[2]) begin
      w[0] = iss_addr; n = 1;
    end
  endfunction

  always @(posedge clk) begin : mdl
    logic [DW-1:0] gw [4];
    int gn, free;
    logic [6:0] cn;
    bit ce;
    if (!rst_n) begin
      m_ctrl = 0; mh = 0; mt = 0; mc = 0; mwp = 0; mrp = 0; mwrap = 0;
    end else begin
      ce = m_ctrl[4];
      build(m_ctrl, gw, gn);
      if (ce) begin
        free = QD - mc;
        if (mc > 0) begin
          mram[mwp] = mq[mh]; mval[mwp] = 1;
          mh = (mh + 1) % QD; mc--;
          if (mwp == DEPTH - 1) begin mwp = 0; mwrap = 1; end else mwp++;
        end
        if (gn > 0 && gn <= free)
          for (int k = 0; k < gn; k++) begin mq[mt] = gw[k]; mt = (mt + 1) % QD; mc++; end
      end else begin
        mh = 0; mt = 0; mc = 0;
      end
      if (rd_req) mrp = (mrp + 1) % DEPTH;
      cn = ctrl_we ? ctrl_wdata : m_ctrl;
      if (ev_start) cn[4] = 1;
      if (ev_stop)  cn[4] = 0;
      if (!ce && cn[4]) begin mrp = 0; mwp = 0; mwrap = 0; end
      m_ctrl = cn;
    end
  end

  always @(negedge clk) if (model_on) begin
    check("R1 ctrl_q model", DW'(ctrl_q), DW'(m_ctrl));
    check("R9 wr_ptr model", DW'(wr_ptr), DW'(mwp));
    check("R11 wrapped model", DW'(wrapped), DW'(mwrap));
    check("R12 rd_ptr model", DW'(rd_ptr), DW'(mrp));
    if (mval[mrp]) check("R12 rd_data model", rd_data, mram[mrp]);
  end

  task automatic step();
    @(negedge clk);
    ctrl_we = 0; ev_start = 0; ev_stop = 0; iss_vld = 0; cof_vld = 0;
    irq_vld = 0; mark_vld = 0; rd_req = 0;
  endtask

  task automatic setmode(logic [6:0] v);
    ctrl_we = 1; ctrl_wdata = 7'h00; step();
    ctrl_we = 1; ctrl_wdata = v;     step();
  endtask

  task automatic readchk(string req, logic [DW-1:0] exp);
    check(req, rd_data, exp);
    rd_req = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    repeat (3) step();
    rst_n = 1;
    step();
    model_on = 1;
    check("R1 reset ctrl_q", DW'(ctrl_q), 0);
    check("R3 reset wr_ptr", DW'(wr_ptr), 0);
    check("R3 reset rd_ptr", DW'(rd_ptr), 0);
    check("R11 reset wrapped", DW'(wrapped), 0);

    // R4 issue mode
    setmode(7'h14);
    iss_vld = 1; iss_addr = 32'h100; step();
    iss_vld = 1; iss_addr = 32'h104; step();
    repeat (4) step();
    check("R4 issue words", DW'(wr_ptr), 2);
    readchk("R4 first issue", 32'h100);
    readchk("R4 second issue", 32'h104);

    // R6 change of flow, event counter wins
    setmode(7'h71);
    cof_vld = 1; cof_src = 32'hA0; cof_dst = 32'hB0; evt_cnt = 32'hE0; ext_cnt = 32'hF0; step();
    repeat (5) step();
    check("R6 cof group size", DW'(wr_ptr), 3);
    readchk("R6 cof src", 32'hA0);
    readchk("R6 cof dst", 32'hB0);
    readchk("R6 cof evt", 32'hE0);

    setmode(7'h51);
    cof_vld = 1; cof_src = 32'hA1; cof_dst = 32'hB1; evt_cnt = 32'hE1; ext_cnt = 32'hF1; step();
    repeat (5) step();
    check("R6 cof ext size", DW'(wr_ptr), 3);
    rd_req = 1; step(); rd_req = 1; step();
    readchk("R6 cof ext word", 32'hF1);

    // R7 interrupt with both counters
    setmode(7'h72);
    irq_vld = 1; irq_last = 32'h11; irq_vec = 32'h22; evt_cnt = 32'h33; ext_cnt = 32'h44; step();
    repeat (6) step();
    check("R7 irq group size", DW'(wr_ptr), 4);
    readchk("R7 irq last", 32'h11);
    readchk("R7 irq vec", 32'h22);
    readchk("R7 irq evt", 32'h33);
    readchk("R7 irq ext", 32'h44);

    // R5 mark on and off
    setmode(7'h18);
    mark_vld = 1; mark_pc = 32'h5A5; step();
    repeat (3) step();
    check("R5 mark recorded", DW'(wr_ptr), 1);
    readchk("R5 mark pc", 32'h5A5);
    setmode(7'h10);
    mark_vld = 1; mark_pc = 32'h777; step();
    repeat (3) step();
    check("R5 mark ignored", DW'(wr_ptr), 0);

    // R8 class bit clear, and priority
    setmode(7'h12);
    cof_vld = 1; cof_src = 32'h9; cof_dst = 32'h8; step();
    repeat (3) step();
    check("R8 cof without bit", DW'(wr_ptr), 0);
    setmode(7'h3F);
    irq_vld = 1; cof_vld = 1; mark_vld = 1; iss_vld = 1;
    irq_last = 32'h61; irq_vec = 32'h62; evt_cnt = 32'h63; cof_src = 32'h70; step();
    repeat (5) step();
    check("R8 irq wins size", DW'(wr_ptr), 3);
    readchk("R8 irq wins word", 32'h61);

    // R9 overflow drops a whole group
    setmode(7'h72);
    for (int c = 0; c < 3; c++) begin
      irq_vld = 1; irq_last = 4*c+1; irq_vec = 4*c+2; evt_cnt = 4*c+3; ext_cnt = 4*c+4; step();
    end
    repeat (10) step();
    check("R9 overflow count", DW'(wr_ptr), 8);
    for (int i = 0; i < 8; i++) readchk("R9 overflow word", DW'(i + 1));

    // R10 stop flushes queued words
    setmode(7'h72);
    irq_vld = 1; irq_last = 32'hC1; irq_vec = 32'hC2; evt_cnt = 32'hC3; ext_cnt = 32'hC4; step();
    ev_stop = 1; step();
    repeat (5) step();
    check("R10 flush wr_ptr", DW'(wr_ptr), 1);
    check("R2 stop bit", DW'(ctrl_q), 32'h62);
    check("R10 only first word", rd_data, 32'hC1);
    ev_start = 1; ev_stop = 1; step();
    check("R2 stop beats start", DW'(ctrl_q), 32'h62);
    ctrl_we = 1; ctrl_wdata = 7'h03; ev_start = 1; step();
    check("R2 start over write", DW'(ctrl_q), 32'h13);
    check("R3 enable clears wr_ptr", DW'(wr_ptr), 0);

    // R11 / R12 wrap
    setmode(7'h14);
    for (int i = 0; i < 70; i++) begin iss_vld = 1; iss_addr = DW'(i); step(); end
    repeat (4) step();
    check("R11 wrap wr_ptr", DW'(wr_ptr), 6);
    check("R11 wrap flag", DW'(wrapped), 1);
    readchk("R11 overwritten word", 32'd64);
    for (int i = 0; i < 63; i++) begin rd_req = 1; step(); end
    check("R12 rd_ptr wrap", DW'(rd_ptr), 0);

    // random phase checked by the model
    for (int c = 0; c < 3000; c++) begin
      if (c % 150 == 0) begin
        ctrl_we = 1; ctrl_wdata = 7'($urandom) | (($urandom % 4 != 0) ? 7'h10 : 7'h00);
      end
      iss_vld = $urandom % 2; iss_addr = $urandom;
      cof_vld = ($urandom % 4 == 0); cof_src = $urandom; cof_dst = $urandom;
      irq_vld = ($urandom % 8 == 0); irq_last = $urandom; irq_vec = $urandom;
      mark_vld = ($urandom % 6 == 0); mark_pc = $urandom;
      evt_cnt = $urandom; ext_cnt = $urandom;
      rd_req = ($urandom % 3 == 0);
      ev_start = ($urandom % 80 == 0);
      ev_stop = ($urandom % 90 == 0);
      step();
    end
    repeat (3) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule